// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is one down-counting interval timer channel. A tick-enable strobe, derived elsewhere from a fixed reference clock, advances it; the system clock only samples that strobe. A register front end gives the channel a reload value and a three-bit mode code. The channel counts down from the reload value and wraps back to it, so the live count always equals the reload value minus the ticks seen since the last restart, taken modulo the reload value.

Two behaviours are built. In the one-shot mode the first terminal count raises one interrupt pulse and latches the output high until software loads a new value. In every other mode the channel raises an interrupt each time the count wraps. In the square-wave mode the output follows the upper half of the count range. A snapshot strobe copies the live count into a holding register, where software can read it without a race.

Top module: `tmr_chan`

## Requirements
- R1: After reset the reload value and the live count are 0xFFFF, the mode is 0, the output and the interrupt are low, and the snapshot register is 0.
- R2: A loaded value of zero is stored and counted as 0xFFFF.
- R3: A load (load_en high) makes the live count equal the loaded value on the next cycle and clears the latched one-shot output.
- R4: Each tick decrements the live count by one. A tick taken while the count is 1 is the terminal count, and the count goes back to the reload value. The count is therefore reload minus (ticks modulo reload).
- R5: In mode 0 (mode_val = 3'd0) the first terminal count after a load pulses the interrupt and sets the output high. The output stays high until the next load, and later terminal counts raise no interrupt.
- R6: In any mode other than 0, every terminal count pulses the interrupt.
- R7: In mode 3 (mode_val = 3'd3) the output is high exactly when the live count is greater than the reload value divided by two, rounded down. In modes other than 0 and 3 the output is low.
- R8: The live count changes only in cycles where tick_en or load_en is high.
- R9: The interrupt is high for exactly the one cycle after the clock edge at which a terminal-count tick was taken.
- R10: A load in the same cycle as a terminal-count tick wins: the count takes the loaded value and no interrupt is raised.
- R11: snap_req copies the live count present in its own cycle into cnt_snap. Otherwise cnt_snap holds its value.
- R12: A mode write (mode_wr) changes the mode without restarting or altering the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance strobe, one tick per high cycle |
| load_en | input | 1 | Load load_val as the reload value and restart |
| load_val | input | 16 | New reload value (0 means 0xFFFF) |
| mode_wr | input | 1 | Write mode_val into the mode register |
| mode_val | input | 3 | Mode code: 0 one-shot, 3 square wave, others periodic |
| snap_req | input | 1 | Capture the live count into cnt_snap |
| cnt_live | output | 16 | Live count |
| cnt_snap | output | 16 | Snapshotted count |
| out_lvl | output | 1 | Channel output level |
| irq | output | 1 | Terminal-count interrupt pulse |

## Verification
The countdown is run with reload values of 10, 7, 1 and 0, and with tick runs shorter than, equal to and several times longer than one period. Comparing the final count with the number of interrupts separates a correct modulo wrap from an off-by-one terminal count. The same runs in mode 0, mode 2 and mode 3 show the difference between the sticky one-shot output and the periodic interrupt, and the odd reload 7 checks that the square-wave threshold is rounded down. Directed cases cover each of these against a terminal count: a load on the same cycle, a load after the one-shot has fired, a mode write alone, idle cycles and a snapshot taken together with a tick.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

   localparam int MODE_W = 3;

   typedef logic [MODE_W-1:0] mode_t;

   localparam mode_t MODE_ONESHOT = 3'd0;
   localparam mode_t MODE_SQWAVE  = 3'd3;

endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             mode_wr,
   input  mode_t            mode_val,
   output logic [CNT_W-1:0] load_norm,
   output logic [CNT_W-1:0] reload_q,
   output mode_t            mode_q
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   // a zero reload stands for the longest period
   assign load_norm = (load_val == '0) ? ALL_ONES : load_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= ALL_ONES;
         mode_q   <= MODE_ONESHOT;
      end else begin
         if (load_en) reload_q <= load_norm;
         if (mode_wr) mode_q   <= mode_val;
      end
   end

endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             restart,
   input  logic [CNT_W-1:0] restart_val,
   input  logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             tc
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_one;

   assign at_one = (cnt_q == ONE);
   // a restart in the same cycle suppresses the terminal count
   assign tc     = tick_en && at_one && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= {CNT_W{1'b1}};
      end else if (restart) begin
         cnt_q <= restart_val;
      end else if (tick_en) begin
         cnt_q <= at_one ? reload_q : cnt_q - ONE;
      end
   end

endmodule

// File: rtl/tmr_out_gen.sv
module tmr_out_gen
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tc,
   input  logic             restart,
   input  mode_t            mode_q,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] reload_q,
   output logic             out_lvl,
   output logic             irq
);

   logic fired_q;
   logic is_oneshot;
   logic above_half;

   assign is_oneshot = (mode_q == MODE_ONESHOT);
   assign above_half = (cnt_q > (reload_q >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= tc && (!is_oneshot || !fired_q);
         if (restart)                fired_q <= 1'b0;
         else if (tc && is_oneshot)  fired_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (mode_q)
         MODE_ONESHOT: out_lvl = fired_q;
         MODE_SQWAVE:  out_lvl = above_half;
         default:      out_lvl = 1'b0;
      endcase
   end

endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
   parameter int CNT_W   = 16,
   parameter bit SNAP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snap_req,
   input  logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_snap
);

   generate
      if (SNAP_EN) begin : g_hold
         logic [CNT_W-1:0] snap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        snap_q <= '0;
            else if (snap_req) snap_q <= cnt_q;
         end
         assign cnt_snap = snap_q;
      end else begin : g_pass
         logic unused_req;
         logic unused_clk;
         logic unused_rst;
         assign unused_req = snap_req;
         assign unused_clk = clk;
         assign unused_rst = rst_n;
         assign cnt_snap   = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit SNAP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             mode_wr,
   input  logic [2:0]       mode_val,
   input  logic             snap_req,
   output logic [CNT_W-1:0] cnt_live,
   output logic [CNT_W-1:0] cnt_snap,
   output logic             out_lvl,
   output logic             irq
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tmr_chan: CNT_W must lie in 2..32");
      end
      if (MODE_W != 3) begin : g_bad_mode
         $error("tmr_chan: mode code must be three bits");
      end
   endgenerate

   logic [CNT_W-1:0] load_norm;
   logic [CNT_W-1:0] reload_q;
   mode_t            mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tc;

   tmr_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_val  (load_val),
      .mode_wr   (mode_wr),
      .mode_val  (mode_val),
      .load_norm (load_norm),
      .reload_q  (reload_q),
      .mode_q    (mode_q)
   );

   tmr_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .restart     (load_en),
      .restart_val (load_norm),
      .reload_q    (reload_q),
      .cnt_q       (cnt_q),
      .tc          (tc)
   );

   tmr_out_gen #(.CNT_W(CNT_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .tc       (tc),
      .restart  (load_en),
      .mode_q   (mode_q),
      .cnt_q    (cnt_q),
      .reload_q (reload_q),
      .out_lvl  (out_lvl),
      .irq      (irq)
   );

   tmr_snap #(.CNT_W(CNT_W), .SNAP_EN(SNAP_EN)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .snap_req (snap_req),
      .cnt_q    (cnt_q),
      .cnt_snap (cnt_snap)
   );

   assign cnt_live = cnt_q;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
   parameter int CNT_W   = 16,
   parameter bit SNAP_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             load_en,
   input logic [CNT_W-1:0] load_val,
   input logic             mode_wr,
   input logic             snap_req,
   input logic [CNT_W-1:0] cnt_live,
   input logic [CNT_W-1:0] cnt_snap,
   input logic             out_lvl,
   input logic             irq,
   input logic [2:0]       mode_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   p_zero_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && load_val == '0) |=> (cnt_live == {CNT_W{1'b1}}));

   p_load_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && load_val != '0) |=> (cnt_live == $past(load_val)));

   p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !load_en && cnt_live > ONE) |=> (cnt_live == $past(cnt_live) - ONE));

   p_oneshot_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'd0 && out_lvl && !load_en && !mode_wr) |=> out_lvl);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !load_en) |=> $stable(cnt_live));

   p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(tick_en) && $past(cnt_live) == ONE));

   p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> !irq);

   p_mode_keeps_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !tick_en && !load_en) |=> $stable(cnt_live));

   generate
      if (SNAP_EN) begin : g_snap_chk
         p_snap_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
            snap_req |=> (cnt_snap == $past(cnt_live)));
         p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !snap_req |=> $stable(cnt_snap));
      end
   endgenerate

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W), .SNAP_EN(SNAP_EN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .load_en  (load_en),
   .load_val (load_val),
   .mode_wr  (mode_wr),
   .snap_req (snap_req),
   .cnt_live (cnt_live),
   .cnt_snap (cnt_snap),
   .out_lvl  (out_lvl),
   .irq      (irq),
   .mode_q   (mode_q)
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        load_en = 1'b0;
   logic [15:0] load_val = '0;
   logic        mode_wr = 1'b0;
   logic [2:0]  mode_val = '0;
   logic        snap_req = 1'b0;
   logic [15:0] cnt_live;
   logic [15:0] cnt_snap;
   logic        out_lvl;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   tmr_chan u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .load_en  (load_en),
      .load_val (load_val),
      .mode_wr  (mode_wr),
      .mode_val (mode_val),
      .snap_req (snap_req),
      .cnt_live (cnt_live),
      .cnt_snap (cnt_snap),
      .out_lvl  (out_lvl),
      .irq      (irq)
   );

   typedef struct packed {
      logic [2:0]  mode;
      logic [15:0] reload;
      logic [15:0] ticks;
      logic [15:0] exp_cnt;
      logic        exp_out;
      logic [7:0]  exp_irq;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{3'd0, 16'd10, 16'd3,  16'd7,      1'b0, 8'd0},
      '{3'd0, 16'd10, 16'd10, 16'd10,     1'b1, 8'd1},
      '{3'd0, 16'd10, 16'd25, 16'd5,      1'b1, 8'd1},
      '{3'd2, 16'd10, 16'd25, 16'd5,      1'b0, 8'd2},
      '{3'd3, 16'd10, 16'd4,  16'd6,      1'b1, 8'd0},
      '{3'd3, 16'd10, 16'd5,  16'd5,      1'b0, 8'd0},
      '{3'd3, 16'd10, 16'd30, 16'd10,     1'b1, 8'd3},
      '{3'd3, 16'd7,  16'd3,  16'd4,      1'b1, 8'd0},
      '{3'd3, 16'd7,  16'd4,  16'd3,      1'b0, 8'd0},
      '{3'd0, 16'd0,  16'd2,  16'hFFFD,   1'b0, 8'd0},
      '{3'd0, 16'd1,  16'd5,  16'd1,      1'b1, 8'd1},
      '{3'd3, 16'd1,  16'd5,  16'd1,      1'b1, 8'd5}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // one clock: inputs already set after a falling edge, results read at the next
   task automatic step();
      @(negedge clk);
      tick_en  = 1'b0;
      load_en  = 1'b0;
      mode_wr  = 1'b0;
      snap_req = 1'b0;
   endtask

   task automatic load(input logic wr_mode, input logic [2:0] m, input logic [15:0] v);
      load_en  = 1'b1;
      load_val = v;
      mode_wr  = wr_mode;
      mode_val = m;
      step();
   endtask

   task automatic ticks(input int n, output int irqs);
      irqs = 0;
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         step();
         if (irq) irqs++;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int nirq;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 count", cnt_live, 16'hFFFF);
      chk("R1 out", {15'd0, out_lvl}, 16'd0);
      chk("R1 irq", {15'd0, irq}, 16'd0);
      chk("R1 snap", cnt_snap, 16'd0);
      // R1 default mode is one-shot: load without mode write
      load(1'b0, 3'd5, 16'd3);
      ticks(3, nirq);
      chk("R1 mode0 out", {15'd0, out_lvl}, 16'd1);
      chk("R1 mode0 irqs", 16'(nirq), 16'd1);

      // table: R2 R4 R5 R6 R7
      for (int k = 0; k < NV; k++) begin
         load(1'b1, TBL[k].mode, TBL[k].reload);
         ticks(int'(TBL[k].ticks), nirq);
         chk($sformatf("R4/R2 row %0d count", k), cnt_live, TBL[k].exp_cnt);
         chk($sformatf("R7/R5 row %0d out", k), {15'd0, out_lvl}, {15'd0, TBL[k].exp_out});
         chk($sformatf("R5/R6 row %0d irqs", k), 16'(nirq), {8'd0, TBL[k].exp_irq});
      end

      // R3 load after one-shot fired clears output and restarts
      load(1'b1, 3'd0, 16'd2);
      ticks(2, nirq);
      chk("R3 fired out", {15'd0, out_lvl}, 16'd1);
      load(1'b0, 3'd0, 16'd5);
      chk("R3 out cleared", {15'd0, out_lvl}, 16'd0);
      chk("R3 count", cnt_live, 16'd5);
      // R3 mid-period reload in square-wave mode
      load(1'b1, 3'd3, 16'd10);
      ticks(3, nirq);
      load(1'b0, 3'd3, 16'd20);
      chk("R3 reload count", cnt_live, 16'd20);
      chk("R7 reload out", {15'd0, out_lvl}, 16'd1);

      // R9 single-cycle interrupt
      load(1'b1, 3'd2, 16'd3);
      ticks(3, nirq);
      chk("R9 irq high", {15'd0, irq}, 16'd1);
      step();
      chk("R9 irq low", {15'd0, irq}, 16'd0);

      // R10 load colliding with terminal count
      load(1'b1, 3'd2, 16'd4);
      ticks(3, nirq);
      chk("R10 pre count", cnt_live, 16'd1);
      tick_en  = 1'b1;
      load_en  = 1'b1;
      load_val = 16'd8;
      step();
      chk("R10 count", cnt_live, 16'd8);
      chk("R10 irq", {15'd0, irq}, 16'd0);

      // R8 idle cycles leave the count
      repeat (5) step();
      chk("R8 hold count", cnt_live, 16'd8);
      chk("R8 irq", {15'd0, irq}, 16'd0);

      // R11 snapshot with concurrent tick
      load(1'b1, 3'd2, 16'd10);
      ticks(3, nirq);
      snap_req = 1'b1;
      tick_en  = 1'b1;
      step();
      chk("R11 snap", cnt_snap, 16'd7);
      chk("R11 count", cnt_live, 16'd6);
      ticks(2, nirq);
      chk("R11 snap held", cnt_snap, 16'd7);

      // R12 mode write alone keeps the count
      load(1'b1, 3'd3, 16'd10);
      ticks(3, nirq);
      chk("R12 sq out", {15'd0, out_lvl}, 16'd1);
      mode_wr  = 1'b1;
      mode_val = 3'd2;
      step();
      chk("R12 count", cnt_live, 16'd7);
      chk("R7 mode2 out low", {15'd0, out_lvl}, 16'd0);
      mode_wr  = 1'b1;
      mode_val = 3'd3;
      step();
      chk("R12 count again", cnt_live, 16'd7);
      chk("R7 mode3 out back", {15'd0, out_lvl}, 16'd1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule